// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Streamer

This block is the readout half of a serial configuration memory that supplies a bitstream to a programmable logic device. It holds a parameterized bit array, filled through a simple write port used for test. The block shifts the array out one bit per rising edge of a serial configuration clock, starting at address 0. The data line is modelled as a value plus an output enable. Several instances can be chained: an active-low cascade output goes low once an instance has run out of data, and that output drives the select input of the next instance.

The role of an instance is fixed when its power-on sequence completes. An instance whose select input is low at that moment becomes the chain master. The master derives the serial clock from the system clock and keeps clocking the downstream instances after its own data is spent. It watches its select input for the done feedback from the target, then issues a fixed tail of clock edges and goes idle. It flags a configuration error when the feedback comes too early or never comes. An instance whose select input is high becomes a slave. A slave synchronizes an external serial clock into the system domain and advances on its rising edges.

Top module: `cfg_stream_top`

## Requirements
- R1: While `oe_i` is low, the bit address returns to 0 within one cycle, `data_oe_o` is 0, `casc_no` is 1 and `cfg_err_o` is 0, whatever the level of `cs_ni`. The first bit presented after `oe_i` rises is the bit at address 0.
- R2: `data_oe_o` is 1 only while `ready_o`, `oe_i` and `!cs_ni` are all true and data remains. A rising serial clock edge seen with `oe_i` low or `cs_ni` high leaves the address unchanged.
- R3: Each qualifying rising serial clock edge advances the address by one. `data_o` equals the stored bit at the current address while driven, and 0 otherwise. For a slave, the advance becomes visible 3 system cycles after the external edge.
- R4: After DEPTH qualifying edges, `casc_no` goes low and stays low until `oe_i` goes low, and `data_oe_o` stays 0 during that time.
- R5: A `cs_ni` level of 0 in the cycle the power-on sequence ends makes the instance the master, with `dclk_oe_o` = 1. A level of 1 makes it a slave, with `dclk_oe_o` = 0 and `dclk_o` = 0.
- R6: A master with its data spent and `cs_ni` still low keeps producing serial clock edges.
- R7: Once a master's data is spent and `cs_ni` is high, it produces exactly 16 further rising edges on `dclk_o`, then holds `dclk_o` low until `oe_i` goes low.
- R8: A master sets `cfg_err_o` if `cs_ni` is high while data remains, or if `cs_ni` stays low for TIMEOUT serial clock edges after its data is spent. The flag holds until `oe_i` goes low. A slave never sets it.
- R9: While `oe_i` is low, the master's clock generator stops and `dclk_o` is 0 from the next cycle.
- R10: After reset, `ready_o` stays 0 for POR_CYCLES system cycles, then goes to 1 and stays there.
- R11: A running master's `dclk_o` has a period of CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Test write strobe into the bit array |
| wr_addr_i | input | $clog2(DEPTH) | Test write bit address |
| wr_data_i | input | 1 | Test write bit value |
| oe_i | input | 1 | High enables output; low resets the address |
| cs_ni | input | 1 | Active-low select; done feedback for a master |
| dclk_i | input | 1 | External serial clock used by a slave |
| dclk_o | output | 1 | Serial clock produced by a master |
| dclk_oe_o | output | 1 | Drive enable for dclk_o (master only) |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Drive enable for data_o |
| casc_no | output | 1 | Active-low cascade output, low once data is spent |
| ready_o | output | 1 | Low during the power-on sequence |
| cfg_err_o | output | 1 | Master configuration error flag |

## Verification
On every cycle, the assertions check several things. The address only ever steps by one or returns to 0, and it holds while the instance is deselected. An `oe_i` low clears the address and the flags. The spent flag and the idle state persist, the error flag appears only on a master, and a stopped generator leaves the clock low. The bench's reference model recomputes the outputs on every cycle from the stored pattern and the observed clock edges. Only the scenarios can show the exact tail of 16 edges, the clock period, the timeout length, and that the error causes and role selection follow the select level at the right moments.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TAIL = 2'd1,
    ST_IDLE = 2'd2
  } mst_state_e;
endpackage

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_bit_o
);
  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_bit_o = mem_q[rd_addr_i];
endmodule

// File: rtl/cfg_clk_src.sv
module cfg_clk_src #(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int HALF = CLK_DIV / 2,
  localparam int CW   = $clog2(HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_en_i,
  input  logic master_i,
  input  logic dclk_ext_i,
  output logic dclk_o,
  output logic edge_o
);
  logic [CW-1:0]        div_q;
  logic                 dclk_q;
  logic                 mpulse_q;
  logic [SYNC_STAGES:0] sync_q;

  // master: divided clock plus one-cycle pulse on each rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      dclk_q   <= 1'b0;
      mpulse_q <= 1'b0;
    end else if (!gen_en_i) begin
      div_q    <= '0;
      dclk_q   <= 1'b0;
      mpulse_q <= 1'b0;
    end else if (div_q == CW'(HALF - 1)) begin
      div_q    <= '0;
      dclk_q   <= ~dclk_q;
      mpulse_q <= ~dclk_q;
    end else begin
      div_q    <= div_q + CW'(1);
      mpulse_q <= 1'b0;
    end
  end

  // slave: synchronizer chain with one extra stage for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], dclk_ext_i};
  end

  assign dclk_o = dclk_q;
  assign edge_o = master_i ? mpulse_q
                           : (sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES]);

  p_stop_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |=> !dclk_q);
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int POR_CYCLES = 8,
  parameter int TIMEOUT    = 32,
  parameter int TAIL_EDGES = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(POR_CYCLES + 1),
  localparam int TW = $clog2(TIMEOUT + 1),
  localparam int LW = $clog2(TAIL_EDGES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          oe_i,
  input  logic          cs_ni,
  input  logic          edge_i,
  output logic          ready_o,
  output logic          master_o,
  output logic [AW-1:0] addr_o,
  output logic          exh_o,
  output mst_state_e    state_o,
  output logic          err_o
);
  logic [PW-1:0] por_q;
  logic          ready_q, master_q;
  logic [AW-1:0] addr_q;
  logic          exh_q;
  mst_state_e    state_q;
  logic          err_q;
  logic [TW-1:0] to_q;
  logic [LW-1:0] tail_q;
  logic          adv;

  // power-on sequence; role latched from select on its last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q    <= '0;
      ready_q  <= 1'b0;
      master_q <= 1'b0;
    end else if (!ready_q) begin
      if (por_q == PW'(POR_CYCLES - 1)) begin
        ready_q  <= 1'b1;
        master_q <= ~cs_ni;
      end else begin
        por_q <= por_q + PW'(1);
      end
    end
  end

  assign adv = ready_q & edge_i & ~cs_ni & ~exh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      exh_q  <= 1'b0;
    end else if (!oe_i) begin
      addr_q <= '0;
      exh_q  <= 1'b0;
    end else if (adv) begin
      if (addr_q == AW'(DEPTH - 1)) exh_q  <= 1'b1;
      else                          addr_q <= addr_q + AW'(1);
    end
  end

  // master completion / error tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      err_q   <= 1'b0;
      to_q    <= '0;
      tail_q  <= '0;
    end else if (!oe_i) begin
      state_q <= ST_RUN;
      err_q   <= 1'b0;
      to_q    <= '0;
      tail_q  <= '0;
    end else if (ready_q && master_q) begin
      unique case (state_q)
        ST_RUN: begin
          if (cs_ni && !exh_q) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cs_ni) begin
            tail_q  <= '0;
            state_q <= ST_TAIL;
          end else if (edge_i && exh_q) begin
            if (to_q == TW'(TIMEOUT - 1)) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              to_q <= to_q + TW'(1);
            end
          end
        end
        ST_TAIL: begin
          if (edge_i) begin
            if (tail_q == LW'(TAIL_EDGES - 1)) state_q <= ST_IDLE;
            else                               tail_q  <= tail_q + LW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign ready_o  = ready_q;
  assign master_o = master_q;
  assign addr_o   = addr_q;
  assign exh_o    = exh_q;
  assign state_o  = state_q;
  assign err_o    = err_q;

  p_oe_low_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (addr_q == '0) && !exh_q && !err_q);
  p_frozen_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && cs_ni) |=> $stable(addr_q) && $stable(exh_q));
  p_single_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q != $past(addr_q)) |-> ((addr_q == $past(addr_q) + AW'(1)) || (addr_q == '0)));
  p_spent_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exh_q && oe_i) |=> exh_q);
  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && oe_i) |=> (state_q == ST_IDLE));
  p_err_master_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> master_q);
  p_ready_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q);
endmodule

// File: rtl/cfg_stream_top.sv
module cfg_stream_top
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int CLK_DIV    = 4,
  parameter int POR_CYCLES = 8,
  parameter int TIMEOUT    = 32,
  parameter int TAIL_EDGES = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
  input  logic                     wr_data_i,
  input  logic                     oe_i,
  input  logic                     cs_ni,
  input  logic                     dclk_i,
  output logic                     dclk_o,
  output logic                     dclk_oe_o,
  output logic                     data_o,
  output logic                     data_oe_o,
  output logic                     casc_no,
  output logic                     ready_o,
  output logic                     cfg_err_o
);
  localparam int AW = $clog2(DEPTH);

  logic          ready, master, exh, err, edge_evt, rd_bit, gen_en;
  logic [AW-1:0] addr;
  mst_state_e    state;

  cfg_seq #(
    .DEPTH(DEPTH), .POR_CYCLES(POR_CYCLES),
    .TIMEOUT(TIMEOUT), .TAIL_EDGES(TAIL_EDGES)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .oe_i(oe_i), .cs_ni(cs_ni),
    .edge_i(edge_evt), .ready_o(ready), .master_o(master),
    .addr_o(addr), .exh_o(exh), .state_o(state), .err_o(err)
  );

  assign gen_en = ready & master & oe_i & (state != ST_IDLE);

  cfg_clk_src #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(2)) i_clk_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .gen_en_i(gen_en), .master_i(master),
    .dclk_ext_i(dclk_i), .dclk_o(dclk_o), .edge_o(edge_evt)
  );

  cfg_bit_store #(.DEPTH(DEPTH)) i_store (
    .clk_i(clk_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(addr), .rd_bit_o(rd_bit)
  );

  assign data_oe_o = ready & oe_i & ~cs_ni & ~exh;
  assign data_o    = data_oe_o & rd_bit;
  assign casc_no   = ~exh;
  assign dclk_oe_o = ready & master;
  assign ready_o   = ready;
  assign cfg_err_o = err;
endmodule

// File: tb/test_cfg_stream_top.sv
module test_cfg_stream_top;
  localparam int PERIOD  = 10;
  localparam int DEPTH   = 64;
  localparam int CLK_DIV = 4;
  localparam int POR     = 8;
  localparam int TO      = 32;
  localparam int TAIL    = 16;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, wr_data, oe, cs_n, dclk_in;
  logic [5:0] wr_addr;
  logic       dclk_o, dclk_oe_o, data_o, data_oe_o, casc_no, ready_o, cfg_err_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(PERIOD / 2) clk = ~clk;

  cfg_stream_top #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .POR_CYCLES(POR),
                   .TIMEOUT(TO), .TAIL_EDGES(TAIL)) i_cfg_stream_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .oe_i(oe), .cs_ni(cs_n), .dclk_i(dclk_in),
    .dclk_o(dclk_o), .dclk_oe_o(dclk_oe_o), .data_o(data_o),
    .data_oe_o(data_oe_o), .casc_no(casc_no), .ready_o(ready_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pat_a(int i); return ((i * 5 + 1) % 3) == 0; endfunction
  function automatic bit pat_b(int i); return bit'((i ^ (i >> 3)) & 1); endfunction

  // behavioural reference model
  bit   m_mem[DEPTH];
  bit   m_ready, m_master, m_exh, m_err, m_dlow;
  int   m_por, m_cnt, m_st, m_to, m_tail;  // m_st: 0 run, 1 tail, 2 idle
  bit   sl_pipe[2];
  bit   prev_dclk_o, prev_dclk_i;
  int   rise_total = 0;
  time  last_rise_t = 0, prev_rise_t = 0;

  task automatic model_reset();
    m_ready = 0; m_master = 0; m_exh = 0; m_err = 0; m_dlow = 1;
    m_por = 0; m_cnt = 0; m_st = 0; m_to = 0; m_tail = 0;
    sl_pipe[0] = 0; sl_pipe[1] = 0; prev_dclk_o = 0; prev_dclk_i = 0;
  endtask

  always @(negedge clk) begin
    bit drv, mrise, srise, ev, dlow_n;
    if (!rst_n) model_reset();
    drv = m_ready && oe && !cs_n && !m_exh;
    chk("R10 ready_o", ready_o, m_ready);
    chk("R5 dclk_oe_o", dclk_oe_o, m_ready && m_master);
    chk("R4 casc_no", casc_no, !m_exh);
    chk("R2 data_oe_o", data_oe_o, drv);
    chk("R3 data_o", data_o, drv ? m_mem[m_cnt] : 1'b0);
    chk("R8 cfg_err_o", cfg_err_o, m_err);
    if (m_dlow) chk("R9 dclk_o low", dclk_o, 0);
    mrise = dclk_o && !prev_dclk_o;
    srise = dclk_in && !prev_dclk_i;
    prev_dclk_o = dclk_o;
    prev_dclk_i = dclk_in;
    if (mrise) begin
      rise_total++;
      prev_rise_t = last_rise_t;
      last_rise_t = $time;
    end
    if (rst_n) begin
      if (wr_en) m_mem[wr_addr] = wr_data;
      ev = m_master ? mrise : sl_pipe[1];
      sl_pipe[1] = sl_pipe[0];
      sl_pipe[0] = srise;
      dlow_n = !(m_ready && m_master && oe && m_st != 2);
      if (!m_ready) begin
        if (m_por == POR - 1) begin m_ready = 1; m_master = !cs_n; end
        else m_por++;
      end else if (!oe) begin
        m_cnt = 0; m_exh = 0; m_err = 0; m_st = 0; m_to = 0; m_tail = 0;
      end else begin
        bit exh_old;
        exh_old = m_exh;
        if (ev && !cs_n && !m_exh) begin
          if (m_cnt == DEPTH - 1) m_exh = 1; else m_cnt++;
        end
        if (m_master) begin
          if (m_st == 0) begin
            if (cs_n && !exh_old) begin m_err = 1; m_st = 2; end
            else if (cs_n) begin m_tail = 0; m_st = 1; end
            else if (ev && exh_old) begin
              if (m_to == TO - 1) begin m_err = 1; m_st = 2; end
              else m_to++;
            end
          end else if (m_st == 1 && ev) begin
            if (m_tail == TAIL - 1) m_st = 2; else m_tail++;
          end
        end
      end
      m_dlow = dlow_n;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(bit sel);
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1; wr_addr = 6'(i); wr_data = sel ? pat_b(i) : pat_a(i);
      tick(1);
    end
    wr_en = 0;
  endtask

  task automatic wait_spent(int limit);
    for (int i = 0; i < limit && casc_no; i++) tick(1);
  endtask

  task automatic sl_pulse();
    dclk_in = 1; tick(3);
    dclk_in = 0; tick(3);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r0;
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = 0; oe = 0; cs_n = 0; dclk_in = 0;
    tick(3);
    rst_n = 1;
    tick(2);
    chk("R10 ready low during power-on", ready_o, 0);
    tick(10);
    chk("R10 ready high after power-on", ready_o, 1);
    chk("R5 master role when select low", dclk_oe_o, 1);
    load(0);

    // master full run
    oe = 1; cs_n = 0;
    tick(1);
    chk("R1 first bit is address 0", data_o, pat_a(0));
    wait_spent(400);
    chk("R4 spent after DEPTH edges", casc_no, 0);
    chk("R11 dclk period", int'(last_rise_t - prev_rise_t), CLK_DIV * PERIOD);
    r0 = rise_total;
    tick(40);
    chk("R6 clock continues after spent", int'(rise_total - r0 >= 8), 1);
    chk("R8 no error before timeout", cfg_err_o, 0);
    cs_n = 1;
    @(negedge clk); #1;
    r0 = rise_total;
    tick(200);
    chk("R7 tail edge count", rise_total - r0, TAIL);
    chk("R7 dclk held low when idle", dclk_o, 0);
    chk("R8 no error on normal finish", cfg_err_o, 0);

    // early done feedback
    oe = 0; tick(2);
    oe = 1; cs_n = 0; tick(60);
    cs_n = 1; tick(3);
    chk("R8 early select high flags error", cfg_err_o, 1);
    oe = 0; tick(2);
    chk("R1 oe low clears error", cfg_err_o, 0);

    // missing done feedback
    cs_n = 0; oe = 1;
    wait_spent(400);
    tick(TO * CLK_DIV + 20);
    chk("R8 timeout flags error", cfg_err_o, 1);
    oe = 0; tick(2);

    // restart mid-run, oe low with select high
    oe = 1; tick(40);
    oe = 0; cs_n = 1; tick(2);
    chk("R1 data disabled with select high", data_oe_o, 0);
    chk("R1 cascade released", casc_no, 1);
    chk("R9 dclk low while oe low", dclk_o, 0);
    cs_n = 0; oe = 1; tick(1);
    chk("R1 restart at address 0", data_o, pat_a(0));
    oe = 0; tick(2);

    // slave role
    rst_n = 0; cs_n = 1; tick(2);
    rst_n = 1; tick(12);
    chk("R5 slave role when select high", dclk_oe_o, 0);
    load(1);
    oe = 1; cs_n = 1;
    for (int i = 0; i < 5; i++) sl_pulse();
    cs_n = 0; tick(1);
    chk("R2 deselected edges ignored", data_o, pat_b(0));
    for (int i = 0; i < 3; i++) sl_pulse();
    chk("R3 slave advanced three bits", data_o, pat_b(3));
    for (int i = 0; i < DEPTH - 3; i++) sl_pulse();
    tick(4);
    chk("R4 slave spent", casc_no, 0);
    chk("R4 slave data released", data_oe_o, 0);
    chk("R8 slave never flags", cfg_err_o, 0);
    chk("R5 slave dclk_o low", dclk_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule